// File: doc/BRIEF.md
# Programmable Serial CRC Accumulator

This block folds a serial bit stream into a cyclic redundancy remainder of up to eight bits. A polynomial byte, written at run time, sets both the active width of the remainder and its feedback taps. The datapath is a modular shift register with one XOR per stage. On every clock where the block is enabled, the bit on `ser_in` is XORed with the top active remainder bit. The result shifts in at the bottom and is XORed into every tapped stage as the register moves toward its most significant bit.

Software drives a small byte-wide register bus with four addresses. Before enabling, it programs the polynomial and a starting remainder (seed). It then streams data bits and disables the block. While the block is disabled, the remainder comes out through a two-read sequence. Outputs and the interrupt stay low while the block is disabled.

Top module: `crc_serial_engine`

## Requirements
- R1: After synchronous reset the polynomial, seed, control and remainder registers are 0, and `ser_out` and `irq` are low.
- R2: The active width W equals one plus the index of the highest set bit of the polynomial byte (address 1). The generator's low terms are g[0]=1 and g[i]=poly[i-1] for 0<i<W. Each enabled clock computes fb = ser_in XOR rem[W-1] and then rem = ((rem<<1) masked to W bits) XOR (fb ? g : 0).
- R3: Exactly one `ser_in` bit is consumed at each rising edge while the enable bit (control address 3, bit 0) is 1. While enable is 0, the remainder holds whatever `ser_in` does.
- R4: A write to the seed address (2) while disabled loads the written byte into the remainder at that edge. While enabled, the same write changes only the seed register and leaves the running remainder untouched.
- R5: Reads return data one cycle after the read strobe. A read of address 0 always returns 0. A read of address 1 returns the remainder when it directly follows a read of address 0 and the block is disabled for both reads. Any other read of address 1 returns the polynomial byte.
- R6: `ser_out` equals rem[W-1] while enabled and is 0 while disabled.
- R7: `irq` is 1 exactly when the block is enabled, W is nonzero and the W active remainder bits are all 0.
- R8: Writes to address 0 have no effect on the remainder.
- R9: With a polynomial byte of 0 (W=0), the remainder holds even while enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address: 0 state, 1 polynomial, 2 seed, 3 control |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| ser_in | input | 1 | Serial data bit, sampled at each enabled rising edge |
| ser_out | output | 1 | Top active remainder bit, gated by enable |
| irq | output | 1 | High while enabled with an all-zero active remainder |

## Verification
Any wrong remainder bit reaches `ser_out` within at most W enabled clocks, as it shifts up to the top active stage. It also corrupts every later remainder, so the final read-back after a stream exposes it. A wrong tap or a wrong width shows up as a mismatch against a bit-serial model over several polynomials, including a plain 8-bit generator with known remainders. A leak of the enable gating shows up at once as a high `ser_out` or `irq` while disabled, or as a changed remainder after idle clocks with `ser_in` toggling.

// File: rtl/crc_pkg.sv
package crc_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned SEL_W  = 2;

    typedef logic [BYTE_W-1:0] crc_byte_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_STATE = 2'd0,
        SEL_POLY  = 2'd1,
        SEL_SEED  = 2'd2,
        SEL_CTRL  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic      wr;
        logic      rd;
        reg_sel_e  sel;
        crc_byte_t wdata;
    } bus_req_t;

    typedef struct packed {
        crc_byte_t len_mask;
        crc_byte_t top_sel;
        crc_byte_t gen_low;
    } crc_geom_t;

    localparam int unsigned CTRL_EN_BIT = 0;

endpackage

// File: rtl/crc_geometry.sv
module crc_geometry
    import crc_pkg::*;
#(
    parameter int unsigned DATA_W = BYTE_W
) (
    input  logic [DATA_W-1:0] poly_i,
    output logic [DATA_W-1:0] len_mask_o,
    output logic [DATA_W-1:0] top_sel_o,
    output logic [DATA_W-1:0] gen_low_o
);

    // Per-stage decode of the polynomial byte into width, top index and taps.
    for (genvar i = 0; i < DATA_W; i++) begin : g_stage
        assign len_mask_o[i] = |poly_i[DATA_W-1:i];
        if (i == DATA_W - 1) begin : g_top
            assign top_sel_o[i] = poly_i[i];
        end else begin : g_mid
            assign top_sel_o[i] = poly_i[i] & ~(|poly_i[DATA_W-1:i+1]);
        end
        if (i == 0) begin : g_lsb
            assign gen_low_o[i] = len_mask_o[0];
        end else begin : g_tap
            assign gen_low_o[i] = poly_i[i-1] & len_mask_o[i];
        end
    end

endmodule

// File: rtl/crc_shift.sv
module crc_shift
    import crc_pkg::*;
#(
    parameter int unsigned DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              ser_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_val_i,
    input  logic [DATA_W-1:0] len_mask_i,
    input  logic [DATA_W-1:0] top_sel_i,
    input  logic [DATA_W-1:0] gen_low_i,
    output logic [DATA_W-1:0] state_o,
    output logic              top_o
);

    logic [DATA_W-1:0] state_q;
    logic [DATA_W-1:0] state_d;
    logic [DATA_W-1:0] shifted;
    logic              fb;
    logic              active;

    assign top_o   = |(state_q & top_sel_i);
    assign fb      = ser_i ^ top_o;
    assign shifted = {state_q[DATA_W-2:0], 1'b0};
    assign active  = |len_mask_i;

    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d = load_val_i;
        end else if (en_i && active) begin
            state_d = len_mask_i & (shifted ^ ({DATA_W{fb}} & gen_low_i));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign state_o = state_q;

    // R3
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_i && !load_i) |=> $stable(state_q));

    // R4
    seed_load_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (state_q == $past(load_val_i)));

    // R2
    width_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (en_i && active && !load_i) |=> ((state_q & ~$past(len_mask_i)) == '0));

    // R9
    zero_poly_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!active && !load_i) |=> $stable(state_q));

endmodule

// File: rtl/crc_regbank.sv
module crc_regbank
    import crc_pkg::*;
#(
    parameter int unsigned DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req_i,
    input  logic [DATA_W-1:0] remainder_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [DATA_W-1:0] poly_o,
    output logic              enable_o,
    output logic              load_o,
    output logic [DATA_W-1:0] load_val_o
);

    logic [DATA_W-1:0] poly_q;
    logic [DATA_W-1:0] seed_q;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] rdata_d;
    logic              armed_q;
    logic              enable;

    assign enable = ctrl_q[CTRL_EN_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            poly_q <= '0;
            seed_q <= '0;
            ctrl_q <= '0;
        end else if (req_i.wr) begin
            unique case (req_i.sel)
                SEL_POLY: poly_q <= req_i.wdata;
                SEL_SEED: seed_q <= req_i.wdata;
                SEL_CTRL: ctrl_q <= req_i.wdata;
                default:  ;
            endcase
        end
    end

    assign load_o     = req_i.wr && (req_i.sel == SEL_SEED) && !enable;
    assign load_val_o = req_i.wdata;

    always_comb begin
        unique case (req_i.sel)
            SEL_STATE: rdata_d = '0;
            SEL_POLY:  rdata_d = (armed_q && !enable) ? remainder_i : poly_q;
            SEL_SEED:  rdata_d = seed_q;
            default:   rdata_d = ctrl_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            armed_q <= 1'b0;
        end else if (req_i.rd) begin
            rdata_q <= rdata_d;
            armed_q <= (req_i.sel == SEL_STATE) && !enable;
        end
    end

    assign rdata_o  = rdata_q;
    assign poly_o   = poly_q;
    assign enable_o = enable;

    // R5
    state_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (req_i.rd && req_i.sel == SEL_STATE) |=> (rdata_q == '0));

    // R5
    enabled_poly_read_chk: assert property (@(posedge clk) disable iff (rst)
        (req_i.rd && req_i.sel == SEL_POLY && enable) |=> (rdata_q == $past(poly_q)));

endmodule

// File: rtl/crc_serial_engine.sv
module crc_serial_engine
    import crc_pkg::*;
#(
    parameter int unsigned DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ser_in,
    output logic              ser_out,
    output logic              irq
);

    bus_req_t          req;
    crc_geom_t         geom;
    logic [DATA_W-1:0] poly;
    logic [DATA_W-1:0] remainder;
    logic [DATA_W-1:0] load_val;
    logic              enable;
    logic              load;
    logic              top_bit;

    assign req.wr    = bus_wr;
    assign req.rd    = bus_rd;
    assign req.sel   = reg_sel_e'(bus_addr);
    assign req.wdata = bus_wdata;

    crc_regbank #(.DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .req_i       (req),
        .remainder_i (remainder),
        .rdata_o     (bus_rdata),
        .poly_o      (poly),
        .enable_o    (enable),
        .load_o      (load),
        .load_val_o  (load_val)
    );

    crc_geometry #(.DATA_W(DATA_W)) u_geom (
        .poly_i     (poly),
        .len_mask_o (geom.len_mask),
        .top_sel_o  (geom.top_sel),
        .gen_low_o  (geom.gen_low)
    );

    crc_shift #(.DATA_W(DATA_W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .en_i       (enable),
        .ser_i      (ser_in),
        .load_i     (load),
        .load_val_i (load_val),
        .len_mask_i (geom.len_mask),
        .top_sel_i  (geom.top_sel),
        .gen_low_i  (geom.gen_low),
        .state_o    (remainder),
        .top_o      (top_bit)
    );

    assign ser_out = enable & top_bit;
    assign irq     = enable & (|geom.len_mask) & ~(|(remainder & geom.len_mask));

    // R6
    out_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |-> !ser_out);

    // R7
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> enable);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!ser_out && !irq && bus_rdata == '0));

endmodule

// File: tb/crc_serial_engine_tb.sv
module crc_serial_engine_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ser_in = 1'b0;
    logic       ser_out;
    logic       irq;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    crc_serial_engine u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ser_in(ser_in), .ser_out(ser_out), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model(input logic [7:0] poly, input logic [7:0] seed,
                                         input logic [63:0] bits, input int n);
        int w = 0;
        logic [7:0] st = seed;
        logic [7:0] mask;
        logic [7:0] g;
        logic fb;
        for (int i = 0; i < 8; i++) if (poly[i]) w = i + 1;
        if (w == 0) return seed;
        mask = 8'((9'd1 << w) - 9'd1);
        g = 8'({poly, 1'b1}) & mask;
        for (int k = 0; k < n; k++) begin
            fb = bits[n-1-k] ^ st[w-1];
            st = ((st << 1) & mask) ^ (fb ? g : 8'h00);
        end
        return st;
    endfunction

    // All tasks start and end just after a falling edge.
    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic fetch(output logic [7:0] r);
        logic [7:0] z;
        bus_read(2'd0, z);
        check("R5 state read", z, 8'h00);
        bus_read(2'd1, r);
    endtask

    task automatic start(input logic [7:0] poly, input logic [7:0] seed);
        bus_write(2'd1, poly);
        bus_write(2'd2, seed);
        bus_write(2'd3, 8'h01);
    endtask

    task automatic shift_bit(input logic b);
        ser_in = b;
        @(negedge clk);
    endtask

    task automatic finish_with(input logic b);
        ser_in = b;
        bus_write(2'd3, 8'h00);
    endtask

    task automatic run_stream(input logic [7:0] poly, input logic [7:0] seed,
                              input logic [63:0] bits, input int n, output logic [7:0] r);
        start(poly, seed);
        for (int i = 0; i < n - 1; i++) shift_bit(bits[n-1-i]);
        finish_with(bits[0]);
        fetch(r);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        check("R1 ser_out", {7'b0, ser_out}, 8'h00);
        check("R1 irq", {7'b0, irq}, 8'h00);
        bus_read(2'd1, d); check("R1 poly", d, 8'h00);
        bus_read(2'd2, d); check("R1 seed", d, 8'h00);
        bus_read(2'd3, d); check("R1 ctrl", d, 8'h00);
        fetch(d); check("R1 remainder", d, 8'h00);
    endtask

    task automatic t_crc8_known;
        logic [7:0] r;
        run_stream(8'h83, 8'h00, 64'h01, 8, r);
        check("R2 crc8 of 01", r, 8'h07);
        run_stream(8'h83, 8'h00, 64'h31, 8, r);
        check("R2 crc8 of 31", r, model(8'h83, 8'h00, 64'h31, 8));
    endtask

    task automatic t_polys;
        logic [7:0] r;
        logic [63:0] pat = 64'hC3A5_96E1_0F5A_7B2D;
        run_stream(8'h8E, 8'hFF, pat, 20, r);
        check("R2 poly 8E", r, model(8'h8E, 8'hFF, pat, 20));
        run_stream(8'h30, 8'h05, pat, 17, r);
        check("R2 width 6", r, model(8'h30, 8'h05, pat, 17));
        run_stream(8'h0C, 8'hF3, pat, 33, r);
        check("R2 width 4 upper cleared", r, model(8'h0C, 8'hF3, pat, 33));
        run_stream(8'hB8, 8'h01, pat, 64, r);
        check("R3 long stream", r, model(8'hB8, 8'h01, pat, 64));
    endtask

    task automatic t_hold_and_ignore;
        logic [7:0] r;
        logic [7:0] r2;
        run_stream(8'h8E, 8'h3C, 64'h5A, 8, r);
        for (int i = 0; i < 6; i++) shift_bit(i[0]);
        check("R6 ser_out low disabled", {7'b0, ser_out}, 8'h00);
        check("R7 irq low disabled", {7'b0, irq}, 8'h00);
        fetch(r2);
        check("R3 hold while disabled", r2, r);
        bus_write(2'd0, 8'h33);
        fetch(r2);
        check("R8 state write ignored", r2, r);
        bus_read(2'd1, r2);
        check("R5 unarmed poly read", r2, 8'h8E);
    endtask

    task automatic t_seed_enabled;
        logic [7:0] r;
        logic [63:0] pat = 64'h0000_0000_0000_9D3;
        start(8'h8E, 8'h5A);
        for (int i = 0; i < 4; i++) shift_bit(pat[11-i]);
        ser_in = pat[7];
        bus_write(2'd2, 8'hFF);
        for (int i = 5; i < 11; i++) shift_bit(pat[11-i]);
        finish_with(pat[0]);
        fetch(r);
        check("R4 seed write while enabled", r, model(8'h8E, 8'h5A, pat, 12));
        bus_write(2'd2, 8'hC6);
        fetch(r);
        check("R4 seed write while disabled", r, 8'hC6);
    endtask

    task automatic t_enabled_read;
        logic [7:0] d;
        start(8'h83, 8'h00);
        ser_in = 1'b0;
        bus_read(2'd0, d);
        check("R5 state read enabled", d, 8'h00);
        bus_read(2'd1, d);
        check("R5 enabled read gives poly", d, 8'h83);
        bus_write(2'd3, 8'h00);
    endtask

    task automatic t_outputs;
        logic [7:0] r;
        start(8'h83, 8'h00);
        check("R7 irq zero seed", {7'b0, irq}, 8'h01);
        for (int i = 0; i < 8; i++) shift_bit(i == 7);
        check("R7 irq low at 07", {7'b0, irq}, 8'h00);
        check("R6 ser_out top of 07", {7'b0, ser_out}, 8'h00);
        for (int i = 0; i < 5; i++) shift_bit(1'b0);
        check("R6 ser_out top of E0", {7'b0, ser_out}, 8'h01);
        bus_write(2'd2, 8'h00);
        finish_with(1'b0);
        start(8'h83, 8'h00);
        for (int i = 0; i < 8; i++) shift_bit(i == 7);
        for (int i = 0; i < 8; i++) shift_bit(i >= 5);
        check("R7 irq on zero remainder", {7'b0, irq}, 8'h01);
        finish_with(1'b0);
        fetch(r);
        check("R2 remainder after crc", r, model(8'h83, 8'h00, 64'h0107, 17));
    endtask

    task automatic t_zero_poly;
        logic [7:0] r;
        start(8'h00, 8'hA5);
        shift_bit(1'b1); shift_bit(1'b0); shift_bit(1'b1);
        check("R7 irq low for zero width", {7'b0, irq}, 8'h00);
        check("R6 ser_out zero width", {7'b0, ser_out}, 8'h00);
        finish_with(1'b1);
        fetch(r);
        check("R9 zero poly hold", r, 8'hA5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_crc8_known();
        t_polys();
        t_hold_and_ignore();
        t_seed_enabled();
        t_enabled_read();
        t_outputs();
        t_zero_poly();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<50000 cycles", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule